// File: doc/BRIEF.md
# Interrupt routing table controller

This block steers a set of level-sensitive interrupt sources onto the interrupt lines of several processor cores. There are 32 sources by default, and each core has four lines. Every source owns one route byte in a small register window. The low nibble of that byte is a mask of target cores and the high nibble is a mask of target lines. The block ANDs each source with a global enable bit, expands it through its route byte, and ORs all sources that hit the same core and line. The result is one registered level output per core/line pair.

Software configures the block over a simple 32-bit register bus with byte strobes. The route bytes can be written one byte at a time. The enable mask is read through one address. It can only be changed through two other addresses: one where written ones set enable bits and one where written ones clear them. A single write can therefore turn on any group of sources, such as the sixteen upper sources together with source 10, without a read-modify-write.

Top module: `irq_route_ctrl`

## Requirements
- R1: While and after reset, with no writes since, every enable bit and route byte reads as zero and every output is low, whatever the sources do.
- R2: Route byte n sits at byte address n. A word read at a word-aligned address 4k returns bytes 4k..4k+3 with byte 4k in bits 7:0. A write updates only the bytes whose strobe bit (bus_strb[b] for bits 8b+7:8b) is set.
- R3: Bit c of a route byte's low nibble selects core c and bit l of its high nibble selects line l. Output bit core*4+line carries that pair, so a route byte of 0x11 drives bit 0 (core 0, line 0) and 0x21 drives bit 1 (core 0, line 1).
- R4: A source whose nibbles have several bits set drives every selected core/line pair. A route byte with either nibble zero drives nothing.
- R5: The enable mask reads back at address 0x24, and writes to 0x24 have no effect.
- R6: Writing to 0x28 sets each enable bit whose data bit is one in a strobed byte lane. All other enable bits keep their value.
- R7: Writing to 0x2C clears each enable bit whose data bit is one in a strobed byte lane. All other enable bits keep their value.
- R8: Reads at 0x28 and 0x2C return the current enable mask.
- R9: An output is high when at least one source is high, enabled, and routed to that core and line. A source that is disabled or low has no effect.
- R10: Each output reflects the sources, enables and route bytes with exactly one clock of latency.
- R11: A single write of 0xFFFF0400 to 0x28 enables sources 16 to 31 and source 10 together.
- R12: Reads of any other address (0x20, 0x30 and above) return zero, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Level interrupt sources |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte lane write strobes |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | NUM_CORE*NUM_LINE | Registered level outputs, bit core*NUM_LINE+line |

## Verification
The bench walks all 256 route byte values for every one of the 32 sources with only that source enabled. A swapped core/line nibble or a wrong output index shows up as a stray bit, and a zero-nibble entry that leaked would light a line it must not. Set and clear writes are tried with partial strobes, so a design that ignored the lanes, or that let zero bits clear or set enables, reads back the wrong mask. Writes to the read-only view address and to unmapped addresses are checked through readback. A latency check samples just before and just after the edge, which catches an output that is combinational or two stages deep.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam logic [7:0] EN_VIEW_OFF = 8'h24;
    localparam logic [7:0] EN_SET_OFF  = 8'h28;
    localparam logic [7:0] EN_CLR_OFF  = 8'h2C;

    localparam int ROUTE_BITS = 8;
    localparam int NIBBLE     = 4;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ROUTE,
        ACC_EN_VIEW,
        ACC_EN_SET,
        ACC_EN_CLR
    } acc_kind_t;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_SRC = 32,
    localparam int WIDX_W = $clog2(NUM_SRC / 4)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic [WIDX_W-1:0] word_idx
);

    localparam logic [ADDR_W-1:0] A_VIEW  = ADDR_W'(EN_VIEW_OFF);
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(EN_SET_OFF);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(EN_CLR_OFF);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(NUM_SRC);

    always_comb begin
        word_idx = addr[WIDX_W+1:2];
        if (addr < A_LIMIT)       kind = ACC_ROUTE;
        else if (addr == A_VIEW)  kind = ACC_EN_VIEW;
        else if (addr == A_SET)   kind = ACC_EN_SET;
        else if (addr == A_CLR)   kind = ACC_EN_CLR;
        else                      kind = ACC_NONE;
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int WIDX_W = $clog2(NUM_SRC / 4),
    localparam int NWORDS = NUM_SRC / 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [WIDX_W-1:0]             word_idx,
    input  logic [31:0]                   wdata,
    input  logic [3:0]                    strb,
    output logic [NUM_SRC*ROUTE_BITS-1:0] route_flat,
    output logic [31:0]                   rd_word
);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic hit_w;
        assign hit_w = we && (word_idx == WIDX_W'(w));
        for (genvar b = 0; b < 4; b++) begin : g_byte
            logic [ROUTE_BITS-1:0] entry_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    entry_q <= '0;
                else if (hit_w && strb[b])
                    entry_q <= wdata[8*b +: 8];
            end
            assign route_flat[(w*4+b)*ROUTE_BITS +: ROUTE_BITS] = entry_q;
        end
    end

    assign rd_word = route_flat[{word_idx, 5'b00000} +: 32];

endmodule

// File: rtl/irq_route_enable.sv
module irq_route_enable #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [31:0]        wdata,
    input  logic [3:0]         strb,
    output logic [NUM_SRC-1:0] en_q
);

    logic [31:0] lane_mask;
    logic [31:0] ones;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{strb[b]}};
    end

    assign ones = wdata & lane_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (set_we)
            en_q <= en_q | ones[NUM_SRC-1:0];
        else if (clr_we)
            en_q <= en_q & ~ones[NUM_SRC-1:0];
    end

endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_LINE = 4,
    localparam int NOUT    = NUM_CORE * NUM_LINE
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            src_irq,
    input  logic [NUM_SRC-1:0]            en_q,
    input  logic [NUM_SRC*ROUTE_BITS-1:0] route_flat,
    output logic [NOUT-1:0]               irq_out
);

    logic [NUM_SRC-1:0] live;
    logic [NOUT-1:0]    hit_vec;

    assign live = src_irq & en_q;

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar l = 0; l < NUM_LINE; l++) begin : g_line
            logic [NUM_SRC-1:0] hit;
            for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
                assign hit[s] = live[s]
                              & route_flat[s*ROUTE_BITS + c]
                              & route_flat[s*ROUTE_BITS + NIBBLE + l];
            end
            assign hit_vec[c*NUM_LINE + l] = |hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_out <= '0;
        else
            irq_out <= hit_vec;
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_LINE = 4,
    parameter int ADDR_W   = 8,
    localparam int WIDX_W  = $clog2(NUM_SRC / 4),
    localparam int NOUT    = NUM_CORE * NUM_LINE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_strb,
    output logic [31:0]        bus_rdata,
    output logic [NOUT-1:0]    irq_out
);

    acc_kind_t                     kind;
    logic [WIDX_W-1:0]             word_idx;
    logic                          wr;
    logic [NUM_SRC*ROUTE_BITS-1:0] route_flat;
    logic [31:0]                   route_word;
    logic [NUM_SRC-1:0]            en_q;

    assign wr = bus_valid && bus_write;

    irq_route_decode #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_dec (
        .addr     (bus_addr),
        .kind     (kind),
        .word_idx (word_idx)
    );

    irq_route_table #(.NUM_SRC(NUM_SRC)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (wr && (kind == ACC_ROUTE)),
        .word_idx   (word_idx),
        .wdata      (bus_wdata),
        .strb       (bus_strb),
        .route_flat (route_flat),
        .rd_word    (route_word)
    );

    irq_route_enable #(.NUM_SRC(NUM_SRC)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr && (kind == ACC_EN_SET)),
        .clr_we (wr && (kind == ACC_EN_CLR)),
        .wdata  (bus_wdata),
        .strb   (bus_strb),
        .en_q   (en_q)
    );

    irq_route_merge #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_LINE(NUM_LINE)) u_mrg (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_irq    (src_irq),
        .en_q       (en_q),
        .route_flat (route_flat),
        .irq_out    (irq_out)
    );

    always_comb begin
        unique case (kind)
            ACC_ROUTE:                          bus_rdata = route_word;
            ACC_EN_VIEW, ACC_EN_SET, ACC_EN_CLR: bus_rdata = 32'(en_q);
            default:                            bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NOUT     = 16,
    parameter int ADDR_W   = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_SRC-1:0]            src_irq,
    input logic                          bus_valid,
    input logic                          bus_write,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic [3:0]                    bus_strb,
    input logic [NOUT-1:0]               irq_out,
    input logic [NUM_SRC-1:0]            en_q,
    input logic [NUM_SRC*ROUTE_BITS-1:0] route_flat
);

    logic set_full, clr_full, en_touch;
    assign set_full = bus_valid && bus_write && bus_strb == 4'hF && bus_addr == ADDR_W'(EN_SET_OFF);
    assign clr_full = bus_valid && bus_write && bus_strb == 4'hF && bus_addr == ADDR_W'(EN_CLR_OFF);
    assign en_touch = bus_valid && bus_write &&
                      (bus_addr == ADDR_W'(EN_SET_OFF) || bus_addr == ADDR_W'(EN_CLR_OFF));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && en_q == '0));

    // R9
    idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_irq & en_q) == '0) |=> (irq_out == '0));

    // R6
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_full |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    // R7
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_full |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_touch |=> $stable(en_q));

    // R2
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> $stable(route_flat));

endmodule

bind irq_route_ctrl irq_route_chk #(
    .NUM_SRC (NUM_SRC),
    .NOUT    (NOUT),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_irq    (src_irq),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_strb   (bus_strb),
    .irq_out    (irq_out),
    .en_q       (en_q),
    .route_flat (route_flat)
);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_irq = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]  m_route [32];
    logic [31:0] m_en;
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    irq_route_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_strb  (bus_strb),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_strb = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_route(input int n, input logic [7:0] v);
        bus_wr(8'(n), {4{v}}, 4'(1 << (n % 4)));
        m_route[n] = v;
    endtask

    task automatic en_set(input logic [31:0] m);
        bus_wr(8'h28, m, 4'hF);
        m_en = m_en | m;
    endtask

    task automatic en_clr(input logic [31:0] m);
        bus_wr(8'h2C, m, 4'hF);
        m_en = m_en & ~m;
    endtask

    function automatic logic [15:0] model_out(input logic [31:0] src);
        logic [15:0] r = '0;
        for (int s = 0; s < 32; s++)
            if (src[s] && m_en[s])
                for (int c = 0; c < 4; c++)
                    for (int l = 0; l < 4; l++)
                        if (m_route[s][c] && m_route[s][4+l]) r[c*4+l] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        m_en = '0;
        for (int n = 0; n < 32; n++) m_route[n] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        src_irq = '1;
        @(negedge clk);
        check("R1 out in reset", 32'(irq_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out after reset", 32'(irq_out), 32'h0);
        bus_rd(8'h24, rd); check("R1 enable after reset", rd, 32'h0);
        for (int w = 0; w < 8; w++) begin
            bus_rd(8'(w*4), rd); check("R1 route word after reset", rd, 32'h0);
        end
        src_irq = '0;

        // R5: view address ignores writes
        bus_wr(8'h24, 32'hFFFF_FFFF, 4'hF);
        bus_rd(8'h24, rd); check("R5 write to view ignored", rd, 32'h0);

        // R11 + R8: one set write for upper half and source 10
        en_set(32'hFFFF_0400);
        bus_rd(8'h24, rd); check("R11 view after set", rd, 32'hFFFF_0400);
        bus_rd(8'h28, rd); check("R8 read set address", rd, 32'hFFFF_0400);
        bus_rd(8'h2C, rd); check("R8 read clear address", rd, 32'hFFFF_0400);

        // R7: clear bit 10 only
        en_clr(32'h0000_0400);
        bus_rd(8'h24, rd); check("R7 clear single bit", rd, 32'hFFFF_0000);

        // R6: set honours lanes
        bus_wr(8'h28, 32'hFFFF_FFFF, 4'b0001); m_en = m_en | 32'h0000_00FF;
        bus_rd(8'h24, rd); check("R6 set lane 0 only", rd, 32'hFFFF_00FF);

        // R7: clear honours lanes
        bus_wr(8'h2C, 32'hFFFF_FFFF, 4'b1000); m_en = m_en & ~32'hFF00_0000;
        bus_rd(8'h24, rd); check("R7 clear lane 3 only", rd, 32'h00FF_00FF);

        // R6/R7: zero bits leave enables unchanged
        en_set(32'h0); en_clr(32'h0);
        bus_rd(8'h24, rd); check("R6 R7 zero bits no change", rd, 32'h00FF_00FF);
        en_clr(32'hFFFF_FFFF);
        bus_rd(8'h24, rd); check("R7 clear all", rd, 32'h0);

        // R2: byte-wise route writes and word readback
        for (int n = 0; n < 32; n++) set_route(n, 8'(n*7 + 3));
        for (int w = 0; w < 8; w++) begin
            bus_rd(8'(w*4), rd);
            check("R2 route word readback", rd,
                  {8'(((w*4+3)*7)+3), 8'(((w*4+2)*7)+3), 8'(((w*4+1)*7)+3), 8'((w*4)*7+3)});
        end

        // R12: unmapped addresses
        bus_wr(8'h30, 32'hFFFF_FFFF, 4'hF);
        bus_wr(8'h20, 32'hFFFF_FFFF, 4'hF);
        bus_rd(8'h30, rd); check("R12 read 0x30", rd, 32'h0);
        bus_rd(8'h20, rd); check("R12 read 0x20", rd, 32'h0);
        bus_rd(8'hFC, rd); check("R12 read 0xFC", rd, 32'h0);
        bus_rd(8'h24, rd); check("R12 enables untouched", rd, 32'h0);
        bus_rd(8'h1C, rd); check("R12 routes untouched", rd, {8'(31*7+3), 8'(30*7+3), 8'(29*7+3), 8'(28*7+3)});

        // clear routes
        for (int w = 0; w < 8; w++) bus_wr(8'(w*4), 32'h0, 4'hF);
        for (int n = 0; n < 32; n++) m_route[n] = '0;

        // R3/R4: exhaustive route byte sweep per source
        for (int s = 0; s < 32; s++) begin
            en_clr(32'hFFFF_FFFF);
            en_set(32'(1) << s);
            for (int v = 0; v < 256; v++) begin
                set_route(s, 8'(v));
                src_irq = 32'(1) << s;
                @(negedge clk);
                if ($countones(v[3:0]) == 1 && $countones(v[7:4]) == 1)
                    check("R3 single route", 32'(irq_out), 32'(model_out(src_irq)));
                else
                    check("R4 multi or empty route", 32'(irq_out), 32'(model_out(src_irq)));
            end
            src_irq = '0;
            set_route(s, 8'h00);
        end

        // R3: named encodings
        en_clr(32'hFFFF_FFFF);
        en_set(32'h0000_0401);
        set_route(10, 8'h21); set_route(0, 8'h11);
        src_irq = 32'h0000_0400;
        @(negedge clk);
        check("R3 0x21 core0 line1", 32'(irq_out), 32'h0000_0002);
        src_irq = 32'h0000_0001;
        @(negedge clk);
        check("R3 0x11 core0 line0", 32'(irq_out), 32'h0000_0001);

        // R10: one clock latency
        src_irq = '0;
        @(negedge clk);
        check("R10 idle", 32'(irq_out), 32'h0);
        src_irq = 32'h0000_0001;
        #1;
        check("R10 not before edge", 32'(irq_out), 32'h0);
        @(negedge clk);
        check("R10 after one edge", 32'(irq_out), 32'h1);
        src_irq = '0;
        #1;
        check("R10 holds before edge", 32'(irq_out), 32'h1);
        @(negedge clk);
        check("R10 drops after edge", 32'(irq_out), 32'h0);

        // R9: disabled source ignored
        src_irq = 32'h0000_0401;
        en_clr(32'h0000_0001);
        @(negedge clk);
        check("R9 disabled source ignored", 32'(irq_out), 32'h0000_0002);

        // R9: random multi-source combining
        for (int it = 0; it < 300; it++) begin
            for (int w = 0; w < 8; w++) begin
                logic [31:0] d;
                d = next_rand();
                bus_wr(8'(w*4), d, 4'hF);
                for (int b = 0; b < 4; b++) m_route[w*4+b] = d[8*b +: 8];
            end
            en_clr(32'hFFFF_FFFF);
            en_set(next_rand());
            src_irq = next_rand();
            @(negedge clk);
            check("R9 combined outputs", 32'(irq_out), 32'(model_out(src_irq)));
        end

        done = 1'b1;
        finish_run();
    end

endmodule